// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the running time value at the instant a timestamp-worthy packet crosses the MAC, in one direction or the other. It keeps two independent capture slots, one fed by the receive path and one by the transmit path. When a slot takes a capture it raises its valid flag and then locks. From then on it ignores every later event, so the value it holds belongs to exactly one packet. Software collects the value as two 32-bit words, low word first and high word second. The read of the high word frees the slot for the next packet.

The receive slot applies a packet filter before capturing. The packet parser lies outside this block. It raises a one-cycle event strobe together with a small descriptor: the protocol version, whether the packet travelled in UDP, and the message type code. A mode input chooses which packets qualify. A second input chooses which message kind qualifies when the version-1 mode is in force. The transmit slot captures on every strobe, provided its enable is set.

Events are fire-and-forget strobes. The block never pushes back on the packet path. An event that arrives while its slot is locked or disabled is dropped. Register reads are single-cycle strobes, and the read data is combinational from the address.

Top module: `tscap_latch`

## Requirements
- R1: After reset both valid flags are 0, and the status word (address 4) reads 0.
- R2: When `tx_en_i` is 1, `tx_evt_i` is 1 and the transmit slot is free, `tx_valid_o` is 1 from the next cycle on. The slot then holds the `time_i` of the strobe cycle: bits 31:0 read at address 2 and bits 63:32 read at address 3.
- R3: A strobe on a direction whose enable is 0 captures nothing, and that direction's valid flag stays 0.
- R4: While a slot is valid, further events change neither its valid flag nor its held value.
- R5: A read (`rd_en_i`=1) of a slot's low word (receive at 0, transmit at 2) leaves the slot locked. A read of its high word (receive at 1, transmit at 3) while valid clears the flag on the next cycle.
- R6: A high-word read while the slot is not valid has no effect. An event in that same cycle is captured normally.
- R7: An event that coincides with the releasing high-word read is dropped. The slot ends invalid and keeps its old value.
- R8: Receive mode 0 (version-1 over UDP) qualifies only packets with version bit 0, UDP bit 1 and message code equal to the selector: code 0 (Sync) when `v1_dreq_sel_i`=0, code 1 (Delay_Req) when it is 1.
- R9: Receive mode 1 qualifies version-2 (`rx_v2_i`=1) event messages (code 0 to 3) carried at layer 2 (`rx_udp_i`=0) only.
- R10: Receive mode 2 qualifies version-2 event messages (code 0 to 3) at either layer.
- R11: Receive mode 3 qualifies every receive strobe, whatever its descriptor.
- R12: The two slots are independent. Releasing or capturing in one leaves the other's flag and value unchanged.
- R13: The status word at address 4 holds the receive valid flag in bit 0 and the transmit valid flag in bit 1, with all other bits 0. Reading it has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_i | input | 64 | Running time value |
| rx_en_i | input | 1 | Receive capture enable |
| tx_en_i | input | 1 | Transmit capture enable |
| rx_mode_i | input | 2 | Receive qualification mode (0 to 3) |
| v1_dreq_sel_i | input | 1 | Version-1 message kind: 0 Sync, 1 Delay_Req |
| rx_evt_i | input | 1 | Receive packet strobe |
| rx_v2_i | input | 1 | Descriptor: 1 for version 2 |
| rx_udp_i | input | 1 | Descriptor: 1 if carried in UDP |
| rx_msg_i | input | 4 | Descriptor: message type code |
| tx_evt_i | input | 1 | Transmit packet strobe |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Read address (0 to 4) |
| rd_data_o | output | 32 | Read data for `rd_addr_i` |
| rx_valid_o | output | 1 | Receive slot holds a capture |
| tx_valid_o | output | 1 | Transmit slot holds a capture |

## Verification
The assertions assume that each strobe and each read lasts a single cycle, and that the descriptor, the time value and the read address are stable and known while they are sampled. The checks on lock and release also rely on a read landing in the cycle its address is presented. The bench drives every input just after the falling edge and holds each strobe for exactly one cycle. It reads status and words without side effects by changing only the address, with `rd_en_i` low.

// File: rtl/tscap_pkg.sv
package tscap_pkg;
  localparam int N_SLOTS  = 2;
  localparam int SLOT_RX  = 0;
  localparam int SLOT_TX  = 1;
  localparam int MSG_W    = 4;
  localparam int ADDR_W   = $clog2(2 * N_SLOTS + 1);

  localparam logic [ADDR_W-1:0] A_RX_LO = ADDR_W'(2 * SLOT_RX);
  localparam logic [ADDR_W-1:0] A_RX_HI = ADDR_W'(2 * SLOT_RX + 1);
  localparam logic [ADDR_W-1:0] A_TX_LO = ADDR_W'(2 * SLOT_TX);
  localparam logic [ADDR_W-1:0] A_TX_HI = ADDR_W'(2 * SLOT_TX + 1);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(2 * N_SLOTS);

  typedef enum logic [1:0] {
    RXM_V1_UDP = 2'd0,
    RXM_V2_L2  = 2'd1,
    RXM_V2_ANY = 2'd2,
    RXM_ALL    = 2'd3
  } rx_mode_e;

  typedef struct packed {
    logic             v2;
    logic             udp;
    logic [MSG_W-1:0] msg;
  } pkt_desc_t;
endpackage

// File: rtl/tscap_filter.sv
module tscap_filter
  import tscap_pkg::*;
(
  input  rx_mode_e  mode_i,
  input  logic      dreq_sel_i,
  input  pkt_desc_t desc_i,
  output logic      match_o
);
  logic v2_event;
  logic v1_hit;

  // version-2 event messages occupy the four lowest type codes
  assign v2_event = desc_i.v2 && (desc_i.msg < MSG_W'(4));
  assign v1_hit   = !desc_i.v2 && desc_i.udp &&
                    (desc_i.msg == {{(MSG_W-1){1'b0}}, dreq_sel_i});

  always_comb begin
    unique case (mode_i)
      RXM_V1_UDP: match_o = v1_hit;
      RXM_V2_L2:  match_o = v2_event && !desc_i.udp;
      RXM_V2_ANY: match_o = v2_event;
      default:    match_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/tscap_slot.sv
module tscap_slot #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              hi_read_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              valid_o,
  output logic [TIME_W-1:0] stamp_o
);
  logic release_now;
  logic take_now;

  // a high read only counts when something is held
  assign release_now = hi_read_i && valid_o;
  assign take_now    = arm_i && !valid_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      stamp_o <= '0;
    end else if (release_now) begin
      valid_o <= 1'b0;
    end else if (take_now) begin
      valid_o <= 1'b1;
      stamp_o <= time_i;
    end
  end
endmodule

// File: rtl/tscap_rdmux.sv
module tscap_rdmux
  import tscap_pkg::*;
#(
  parameter int TIME_W = 64,
  localparam int WORD_W = TIME_W / 2
) (
  input  logic                           rd_en_i,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  input  logic [N_SLOTS-1:0][TIME_W-1:0] stamp_i,
  input  logic [N_SLOTS-1:0]             valid_i,
  output logic [WORD_W-1:0]              rd_data_o,
  output logic [N_SLOTS-1:0]             hi_read_o
);
  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < N_SLOTS; s++) begin
      if (rd_addr_i == ADDR_W'(2 * s))
        rd_data_o = stamp_i[s][WORD_W-1:0];
      if (rd_addr_i == ADDR_W'(2 * s + 1))
        rd_data_o = stamp_i[s][TIME_W-1:WORD_W];
    end
    if (rd_addr_i == A_STAT)
      rd_data_o = {{(WORD_W-N_SLOTS){1'b0}}, valid_i};
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_hi
    assign hi_read_o[s] = rd_en_i && (rd_addr_i == ADDR_W'(2 * s + 1));
  end
endmodule

// File: rtl/tscap_latch.sv
module tscap_latch
  import tscap_pkg::*;
#(
  parameter int TIME_W = 64,
  localparam int WORD_W = TIME_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_i,
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic [1:0]        rx_mode_i,
  input  logic              v1_dreq_sel_i,
  input  logic              rx_evt_i,
  input  logic              rx_v2_i,
  input  logic              rx_udp_i,
  input  logic [MSG_W-1:0]  rx_msg_i,
  input  logic              tx_evt_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rx_valid_o,
  output logic              tx_valid_o
);
  pkt_desc_t                      desc;
  logic                           rx_match;
  logic [N_SLOTS-1:0]             arm;
  logic [N_SLOTS-1:0]             hi_read;
  logic [N_SLOTS-1:0]             valid;
  logic [N_SLOTS-1:0][TIME_W-1:0] stamp;

  assign desc = '{v2: rx_v2_i, udp: rx_udp_i, msg: rx_msg_i};

  tscap_filter u_filter (
    .mode_i     (rx_mode_e'(rx_mode_i)),
    .dreq_sel_i (v1_dreq_sel_i),
    .desc_i     (desc),
    .match_o    (rx_match)
  );

  assign arm[SLOT_RX] = rx_en_i && rx_evt_i && rx_match;
  assign arm[SLOT_TX] = tx_en_i && tx_evt_i;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    tscap_slot #(.TIME_W(TIME_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (arm[s]),
      .hi_read_i (hi_read[s]),
      .time_i    (time_i),
      .valid_o   (valid[s]),
      .stamp_o   (stamp[s])
    );
  end

  tscap_rdmux #(.TIME_W(TIME_W)) u_rdmux (
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .stamp_i   (stamp),
    .valid_i   (valid),
    .rd_data_o (rd_data_o),
    .hi_read_o (hi_read)
  );

  assign rx_valid_o = valid[SLOT_RX];
  assign tx_valid_o = valid[SLOT_TX];
endmodule

// File: rtl/tscap_latch_chk.sv
module tscap_latch_chk
  import tscap_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TIME_W-1:0] time_i,
  input logic              rx_en_i,
  input logic              tx_en_i,
  input logic              rx_evt_i,
  input logic              tx_evt_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              rx_valid_o,
  input logic              tx_valid_o,
  input logic [TIME_W-1:0] rx_stamp,
  input logic [TIME_W-1:0] tx_stamp
);
  // R2
  tx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_i && tx_evt_i && !tx_valid_o |=> tx_valid_o && (tx_stamp == $past(time_i)));

  // R3
  tx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i && !tx_valid_o |=> !tx_valid_o);

  // R3
  rx_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> $past(rx_evt_i && rx_en_i));

  // R4
  rx_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !(rd_en_i && rd_addr_i == A_RX_HI) |=> rx_valid_o && $stable(rx_stamp));

  // R4
  tx_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !(rd_en_i && rd_addr_i == A_TX_HI) |=> tx_valid_o && $stable(tx_stamp));

  // R5
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && rd_addr_i == A_RX_HI && rx_valid_o |=> !rx_valid_o);

  // R7
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && rd_addr_i == A_TX_HI && tx_valid_o |=> !tx_valid_o && $stable(tx_stamp));
endmodule

bind tscap_latch tscap_latch_chk #(.TIME_W(TIME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .time_i     (time_i),
  .rx_en_i    (rx_en_i),
  .tx_en_i    (tx_en_i),
  .rx_evt_i   (rx_evt_i),
  .tx_evt_i   (tx_evt_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rx_valid_o (rx_valid_o),
  .tx_valid_o (tx_valid_o),
  .rx_stamp   (stamp[SLOT_RX]),
  .tx_stamp   (stamp[SLOT_TX])
);

// File: tb/tscap_latch_test.sv
`timescale 1ns/1ps
module tscap_latch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_v = '0;
  logic        rx_en = 1'b0, tx_en = 1'b0;
  logic [1:0]  rx_mode = 2'd0;
  logic        dsel = 1'b0;
  logic        rx_evt = 1'b0, rx_v2 = 1'b0, rx_udp = 1'b0;
  logic [3:0]  rx_msg = '0;
  logic        tx_evt = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rx_valid, tx_valid;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tscap_latch uut (
    .clk(clk), .rst_n(rst_n), .time_i(time_v), .rx_en_i(rx_en), .tx_en_i(tx_en),
    .rx_mode_i(rx_mode), .v1_dreq_sel_i(dsel), .rx_evt_i(rx_evt), .rx_v2_i(rx_v2),
    .rx_udp_i(rx_udp), .rx_msg_i(rx_msg), .tx_evt_i(tx_evt), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rx_valid_o(rx_valid), .tx_valid_o(tx_valid)
  );

  // {mode[1:0], sel, v2, udp, msg[3:0], expect}
  localparam logic [9:0] VEC [16] = '{
    {2'd0, 1'b0, 1'b0, 1'b1, 4'd0,  1'b1},
    {2'd0, 1'b0, 1'b0, 1'b1, 4'd1,  1'b0},
    {2'd0, 1'b1, 1'b0, 1'b1, 4'd1,  1'b1},
    {2'd0, 1'b1, 1'b0, 1'b1, 4'd0,  1'b0},
    {2'd0, 1'b0, 1'b1, 1'b1, 4'd0,  1'b0},
    {2'd0, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 4'd0,  1'b1},
    {2'd1, 1'b0, 1'b1, 1'b0, 4'd3,  1'b1},
    {2'd1, 1'b0, 1'b1, 1'b1, 4'd0,  1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 4'd4,  1'b0},
    {2'd2, 1'b0, 1'b1, 1'b1, 4'd1,  1'b1},
    {2'd2, 1'b0, 1'b1, 1'b0, 4'd2,  1'b1},
    {2'd2, 1'b0, 1'b1, 1'b1, 4'd8,  1'b0},
    {2'd2, 1'b0, 1'b0, 1'b1, 4'd0,  1'b0},
    {2'd3, 1'b0, 1'b0, 1'b0, 4'd9,  1'b1},
    {2'd3, 1'b0, 1'b1, 1'b1, 4'd15, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_rx(input logic [63:0] t);
    @(negedge clk); rx_evt = 1'b1; time_v = t;
    @(negedge clk); rx_evt = 1'b0;
  endtask

  task automatic pulse_tx(input logic [63:0] t);
    @(negedge clk); tx_evt = 1'b1; time_v = t;
    @(negedge clk); tx_evt = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic peek64(input logic [2:0] lo, output logic [63:0] v);
    logic [31:0] l, h;
    peek(lo, l);
    peek(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx valid", rx_valid, 0);
    chk("R1 tx valid", tx_valid, 0);
    peek(3'd4, d);
    chk("R1 status", d, 0);

    // table walk over receive qualification modes (R8..R11)
    rx_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      string tag;
      logic [63:0] t;
      t = 64'h1000_0000_0000_0000 + 64'(i) * 64'h0001_0001_0101_0011;
      case (VEC[i][9:8])
        2'd0: tag = "R8";
        2'd1: tag = "R9";
        2'd2: tag = "R10";
        default: tag = "R11";
      endcase
      @(negedge clk);
      rx_mode = VEC[i][9:8]; dsel = VEC[i][7]; rx_v2 = VEC[i][6];
      rx_udp = VEC[i][5]; rx_msg = VEC[i][4:1];
      pulse_rx(t);
      chk(tag, rx_valid, VEC[i][0]);
      if (VEC[i][0]) begin
        peek64(3'd0, v);
        chk(tag, v, t);
        rd(3'd1, d);
      end
    end

    // R2 transmit capture
    tx_en = 1'b1;
    pulse_tx(64'hCAFE_0001_DEAD_0002);
    chk("R2 valid", tx_valid, 1);
    peek64(3'd2, v);
    chk("R2 stamp", v, 64'hCAFE_0001_DEAD_0002);

    // R4 locked slot ignores later events
    pulse_tx(64'h1111_2222_3333_4444);
    chk("R4 valid", tx_valid, 1);
    peek64(3'd2, v);
    chk("R4 stamp", v, 64'hCAFE_0001_DEAD_0002);

    // R12 + R13 both held, status read without side effect
    rx_mode = 2'd3;
    pulse_rx(64'h0A0A_0B0B_0C0C_0D0D);
    rd(3'd4, d);
    chk("R13 status", d, 32'h3);
    chk("R13 rx kept", rx_valid, 1);
    chk("R13 tx kept", tx_valid, 1);

    // R5 low read keeps lock
    rd(3'd2, d);
    chk("R5 low word", d, 32'hDEAD_0002);
    chk("R5 low keeps", tx_valid, 1);

    // R12 rx release leaves tx alone
    rd(3'd1, d);
    chk("R12 rx hi", d, 32'h0A0A_0B0B);
    chk("R12 rx freed", rx_valid, 0);
    chk("R12 tx kept", tx_valid, 1);
    peek64(3'd2, v);
    chk("R12 tx stamp", v, 64'hCAFE_0001_DEAD_0002);

    // R7 event coinciding with release is dropped
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd3; tx_evt = 1'b1; time_v = 64'h7777_7777_7777_7777;
    @(negedge clk);
    rd_en = 1'b0; tx_evt = 1'b0;
    chk("R7 valid", tx_valid, 0);
    peek64(3'd2, v);
    chk("R7 stamp", v, 64'hCAFE_0001_DEAD_0002);

    // R6 high read while empty has no effect; same-cycle event captured
    rd(3'd3, d);
    chk("R6 stays empty", tx_valid, 0);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd3; tx_evt = 1'b1; time_v = 64'h5555_6666_7777_8888;
    @(negedge clk);
    rd_en = 1'b0; tx_evt = 1'b0;
    chk("R6 captured", tx_valid, 1);
    peek64(3'd2, v);
    chk("R6 stamp", v, 64'h5555_6666_7777_8888);
    rd(3'd3, d);

    // R3 disabled directions ignore strobes
    tx_en = 1'b0; rx_en = 1'b0;
    pulse_tx(64'h9);
    pulse_rx(64'h9);
    chk("R3 tx off", tx_valid, 0);
    chk("R3 rx off", rx_valid, 0);
    peek(3'd4, d);
    chk("R3 status", d, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule